// File: doc/BRIEF.md
# Adaptive Bit-Timing Tracker

This block recovers bit timing for a two-wire differential serial receiver that runs from a fast oversampling clock. A start-of-packet pulse seeds a fixed-point bit period and sample position. From then on the block raises a mid-bit strobe at each bit centre and an edge strobe half a period earlier. The receiver samples the line on those strobes and hands the two symbols back. The block compares them. Whenever a data transition arrives, it trims the period and the phase so that the strobes follow a transmitter whose clock is slightly fast or slow.

Two line rates are supported, and one input picks the rate. The block does not decode symbols or frame packets. It sees only the two-bit line code at each strobe: bit 1 is the positive wire and bit 0 the negative wire, 2'b00 is single-ended zero, 2'b11 is single-ended one, and 2'b01 and 2'b10 are the two differential states.

Top module: `bit_trk`

## Requirements
- R1: After reset, and until the first start-of-packet pulse, neither strobe is raised.
- R2: On a start-of-packet pulse the period reloads to SAMPLE_HZ/rate in Q16 fixed point. The rate is FAST_HZ when `rate_fast_i`=1 and SLOW_HZ when it is 0.
- R3: The position is seeded to the pulse's sample index, minus half a period, plus half a sample, plus one period. A mid strobe fires when the integer part of the position equals the free-running sample count. At 32 samples per bit, the first mid strobe comes 16 cycles after the pulse cycle.
- R4: Each mid strobe advances the position by the period in force before any correction. The edge strobe fires where the integer part of (position − floor(period/2)) equals the count. No edge strobe is issued for the first bit, so the first edge strobe comes one full period after the pulse.
- R5: A correction is made only at a mid strobe, and only when all three hold: the mid symbol is 2'b01 or 2'b10; it differs from the previous mid symbol; and the symbol latched at the last edge strobe is 2'b01 or 2'b10. The previous symbol after a pulse is 2'b01 at the fast rate and 2'b10 at the slow rate. The latched edge symbol after a pulse is 2'b00.
- R6: An early edge is one where the latched edge symbol equals the new mid symbol. On an early edge the period drops by floor(P·33/2^15), and the next position is pos + P_old − floor(P_new·41/2^12).
- R7: On a late edge (any other qualifying transition) the period grows by the same step, and the phase step is added to the next position.
- R8: The period stays within nominal ± floor(nominal·3/100) of the selected rate.
- R9: A start-of-packet pulse while tracking is active re-seeds the period, position, rate and symbol history at once.
- R10: The mid strobe and the edge strobe are never raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_i | input | 1 | One-cycle pulse in the sample where the start-of-packet edge was seen |
| rate_fast_i | input | 1 | Rate select, sampled with sop_i: 1 fast, 0 slow |
| edge_line_i | input | 2 | Line code, sampled in the edge-strobe cycle |
| mid_line_i | input | 2 | Line code, sampled in the mid-strobe cycle |
| mid_stb_o | output | 1 | Mid-bit sample strobe |
| edge_stb_o | output | 1 | Expected edge-position strobe |

## Verification
The bench builds the block with its defaults: a 48 MHz sample rate against 1.5 MHz and 12 MHz line rates. That gives exactly 32 and 4 samples per bit, so the nominal strobe offsets (16/32 and 2/4 cycles) and the spacing are whole numbers that can be checked directly. At 32 samples per bit, one 0.1 % period step and one 1 % phase step move the strobe train by a visible fraction of a cycle within about ten bits. A run of 150 steady early or late transitions drives the period into the ±3 % limits. There the mid-strobe spacing settles to 30–31 or 33–34 cycles, which separates a clamped period from one that keeps drifting.

// File: rtl/bit_trk_pkg.sv
package bit_trk_pkg;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_DM  = 2'b01,
        LN_DP  = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    localparam int WIDE_W = 48;
    typedef logic [WIDE_W-1:0] wide_t;

    typedef struct packed {
        logic adj;
        logic early;
    } nudge_t;

    function automatic logic is_diff(line_t s);
        return (s == LN_DM) || (s == LN_DP);
    endfunction

    // Differential state seen right after the start edge.
    function automatic line_t start_state(logic fast);
        return fast ? LN_DM : LN_DP;
    endfunction

    // About 0.1 % of a period.
    function automatic wide_t period_step(wide_t p);
        return (p * wide_t'(33)) >> 15;
    endfunction

    // About 1 % of a period.
    function automatic wide_t phase_step(wide_t p);
        return (p * wide_t'(41)) >> 12;
    endfunction

endpackage

// File: rtl/bit_trk_count.sv
module bit_trk_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst) cnt_o <= '0;
        else     cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/bit_trk_period.sv
module bit_trk_period
    import bit_trk_pkg::*;
#(
    parameter int unsigned SAMPLE_HZ = 48_000_000,
    parameter int unsigned SLOW_HZ   = 1_500_000,
    parameter int unsigned FAST_HZ   = 12_000_000,
    parameter int          FRAC_W    = 16,
    parameter int          POS_W     = 32,
    parameter int          TOL_PCT   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             rate_i,
    input  nudge_t           nudge_i,
    output logic [POS_W-1:0] per_q,
    output logic [POS_W-1:0] per_d
);
    logic [POS_W-1:0] nom_w [2];
    logic [POS_W-1:0] lo_w  [2];
    logic [POS_W-1:0] hi_w  [2];

    for (genvar g = 0; g < 2; g++) begin : g_rate
        localparam logic [63:0] RATE = (g == 1) ? 64'(FAST_HZ) : 64'(SLOW_HZ);
        localparam logic [63:0] NOM  = (64'(SAMPLE_HZ) << FRAC_W) / RATE;
        localparam logic [63:0] TOL  = (NOM * 64'(TOL_PCT)) / 64'd100;
        assign nom_w[g] = NOM[POS_W-1:0];
        assign lo_w[g]  = POS_W'(NOM - TOL);
        assign hi_w[g]  = POS_W'(NOM + TOL);
    end

    logic             rate_q;
    logic [POS_W-1:0] step, cand;

    always_comb begin
        step = POS_W'(period_step(wide_t'(per_q)));
        cand = nudge_i.early ? (per_q - step) : (per_q + step);
        if (cand < lo_w[rate_q]) cand = lo_w[rate_q];
        if (cand > hi_w[rate_q]) cand = hi_w[rate_q];
        if (load_i)           per_d = nom_w[rate_i];
        else if (nudge_i.adj) per_d = cand;
        else                  per_d = per_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q  <= '0;
            rate_q <= 1'b0;
        end else begin
            per_q <= per_d;
            if (load_i) rate_q <= rate_i;
        end
    end
endmodule

// File: rtl/bit_trk_phase.sv
module bit_trk_phase
    import bit_trk_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    adv_i,
    input  nudge_t                  nudge_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [CNT_W+FRAC_W-1:0] per_q_i,
    input  logic [CNT_W+FRAC_W-1:0] per_d_i,
    output logic                    mid_stb_o,
    output logic                    edge_stb_o
);
    localparam int POS_W = CNT_W + FRAC_W;
    localparam logic [POS_W-1:0] HALF_SMP = POS_W'(1) << (FRAC_W - 1);

    logic             act_q;
    logic [POS_W-1:0] pos_q, pos_d, edge_pt, ph;

    always_comb begin
        ph    = POS_W'(phase_step(wide_t'(per_d_i)));
        pos_d = pos_q;
        if (load_i)
            pos_d = {cnt_i, {FRAC_W{1'b0}}} - (per_d_i >> 1) + HALF_SMP + per_d_i;
        else if (adv_i) begin
            pos_d = pos_q + per_q_i;
            if (nudge_i.adj) pos_d = nudge_i.early ? (pos_d - ph) : (pos_d + ph);
        end
    end

    assign edge_pt    = pos_q - (per_q_i >> 1);
    assign mid_stb_o  = act_q && (pos_q[POS_W-1:FRAC_W] == cnt_i);
    assign edge_stb_o = act_q && (edge_pt[POS_W-1:FRAC_W] == cnt_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
            if (load_i) act_q <= 1'b1;
        end
    end
endmodule

// File: rtl/bit_trk.sv
module bit_trk
    import bit_trk_pkg::*;
#(
    parameter int unsigned SAMPLE_HZ = 48_000_000,
    parameter int unsigned SLOW_HZ   = 1_500_000,
    parameter int unsigned FAST_HZ   = 12_000_000,
    parameter int          CNT_W     = 16,
    parameter int          FRAC_W    = 16,
    parameter int          TOL_PCT   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sop_i,
    input  logic       rate_fast_i,
    input  logic [1:0] edge_line_i,
    input  logic [1:0] mid_line_i,
    output logic       mid_stb_o,
    output logic       edge_stb_o
);
    localparam int POS_W = CNT_W + FRAC_W;

    logic [CNT_W-1:0] cnt;
    logic [POS_W-1:0] per_q, per_d;
    line_t            edge_q, prev_q, mid_s, edge_s;
    nudge_t           nudge;
    logic             adv;

    assign mid_s  = line_t'(mid_line_i);
    assign edge_s = line_t'(edge_line_i);
    assign adv    = mid_stb_o && !sop_i;

    always_comb begin
        nudge.adj   = adv && is_diff(mid_s) && (mid_s != prev_q) && is_diff(edge_q);
        nudge.early = (edge_q == mid_s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= LN_SE0;
            prev_q <= LN_SE0;
        end else if (sop_i) begin
            edge_q <= LN_SE0;
            prev_q <= start_state(rate_fast_i);
        end else begin
            if (edge_stb_o) edge_q <= edge_s;
            if (mid_stb_o)  prev_q <= mid_s;
        end
    end

    bit_trk_count #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    bit_trk_period #(
        .SAMPLE_HZ (SAMPLE_HZ),
        .SLOW_HZ   (SLOW_HZ),
        .FAST_HZ   (FAST_HZ),
        .FRAC_W    (FRAC_W),
        .POS_W     (POS_W),
        .TOL_PCT   (TOL_PCT)
    ) u_per (
        .clk     (clk),
        .rst     (rst),
        .load_i  (sop_i),
        .rate_i  (rate_fast_i),
        .nudge_i (nudge),
        .per_q   (per_q),
        .per_d   (per_d)
    );

    bit_trk_phase #(
        .CNT_W  (CNT_W),
        .FRAC_W (FRAC_W)
    ) u_pha (
        .clk        (clk),
        .rst        (rst),
        .load_i     (sop_i),
        .adv_i      (adv),
        .nudge_i    (nudge),
        .cnt_i      (cnt),
        .per_q_i    (per_q),
        .per_d_i    (per_d),
        .mid_stb_o  (mid_stb_o),
        .edge_stb_o (edge_stb_o)
    );
endmodule

// File: rtl/bit_trk_chk.sv
module bit_trk_chk #(
    parameter int unsigned SAMPLE_HZ = 48_000_000,
    parameter int unsigned SLOW_HZ   = 1_500_000,
    parameter int unsigned FAST_HZ   = 12_000_000,
    parameter int          FRAC_W    = 16,
    parameter int          POS_W     = 32,
    parameter int          TOL_PCT   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             sop_i,
    input logic             rate_fast_i,
    input logic             mid_stb_o,
    input logic             edge_stb_o,
    input logic [POS_W-1:0] per_q
);
    localparam logic [63:0] NS = (64'(SAMPLE_HZ) << FRAC_W) / 64'(SLOW_HZ);
    localparam logic [63:0] NF = (64'(SAMPLE_HZ) << FRAC_W) / 64'(FAST_HZ);
    localparam logic [63:0] TS = (NS * 64'(TOL_PCT)) / 64'd100;
    localparam logic [63:0] TF = (NF * 64'(TOL_PCT)) / 64'd100;

    logic armed, rate_c;
    logic [63:0] per_w;
    assign per_w = 64'(per_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            rate_c <= 1'b0;
        end else if (sop_i) begin
            armed  <= 1'b1;
            rate_c <= rate_fast_i;
        end
    end

    p_quiet_before_sop_r1: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (!mid_stb_o && !edge_stb_o));

    p_nominal_reload_r2: assert property (@(posedge clk) disable iff (rst)
        sop_i |=> (per_w == ($past(rate_fast_i) ? NF : NS)));

    p_no_mid_after_sop_r3: assert property (@(posedge clk) disable iff (rst)
        sop_i |=> !mid_stb_o);

    p_mid_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        mid_stb_o |=> !mid_stb_o);

    p_period_clamp_r8: assert property (@(posedge clk) disable iff (rst)
        armed |-> (rate_c ? (per_w >= NF - TF && per_w <= NF + TF)
                          : (per_w >= NS - TS && per_w <= NS + TS)));

    p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mid_stb_o, edge_stb_o}));
endmodule

bind bit_trk bit_trk_chk #(
    .SAMPLE_HZ (SAMPLE_HZ),
    .SLOW_HZ   (SLOW_HZ),
    .FAST_HZ   (FAST_HZ),
    .FRAC_W    (FRAC_W),
    .POS_W     (CNT_W + FRAC_W),
    .TOL_PCT   (TOL_PCT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sop_i       (sop_i),
    .rate_fast_i (rate_fast_i),
    .mid_stb_o   (mid_stb_o),
    .edge_stb_o  (edge_stb_o),
    .per_q       (per_q)
);

// File: tb/bit_trk_test.sv
`timescale 1ns/1ps
module bit_trk_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sop = 1'b0;
    logic       rate_fast = 1'b0;
    logic [1:0] edge_line = 2'b00;
    logic [1:0] mid_line = 2'b00;
    logic       mid_stb, edge_stb;

    always #4 clk = ~clk;

    bit_trk uut (
        .clk         (clk),
        .rst         (rst),
        .sop_i       (sop),
        .rate_fast_i (rate_fast),
        .edge_line_i (edge_line),
        .mid_line_i  (mid_line),
        .mid_stb_o   (mid_stb),
        .edge_stb_o  (edge_stb)
    );

    // Expected constants from the requirements (48 MHz / 1.5 MHz / 12 MHz).
    localparam logic [31:0] NOM_S = (32'd48_000_000 / 32'd1_500_000) << 16;
    localparam logic [31:0] NOM_F = (32'd48_000_000 / 32'd12_000_000) << 16;

    int checks = 0, fails = 0, cyc = 0;
    logic [15:0] m_cnt;
    logic [31:0] m_pos, m_per;
    logic        m_act, m_rate, req_sop;
    logic [1:0]  m_prev, m_edge, cur;
    int pol, nstb, sop_cyc, first_mid, first_edge, last_mid, gap, nmid;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit diff_sym(input logic [1:0] s);
        return (s == 2'b01) || (s == 2'b10);
    endfunction

    // One cycle: compare, drive, advance the expectation, move to next negedge.
    task automatic tick();
        logic em, ee, tr, early;
        logic [31:0] ept, pn, nom, tol, lo, hi;
        logic [63:0] st, ph;
        em  = m_act && (m_pos[31:16] == m_cnt);
        ept = m_pos - (m_per >> 1);
        ee  = m_act && (ept[31:16] == m_cnt);
        if (mid_stb || edge_stb) nstb++;
        if (em || ee || mid_stb || edge_stb) begin
            chk(mid_stb == em, "R4 mid strobe cycle", int'(mid_stb), int'(em));
            chk(edge_stb == ee, "R4 edge strobe cycle", int'(edge_stb), int'(ee));
            chk(!(mid_stb && edge_stb), "R10 single strobe", int'(mid_stb & edge_stb), 0);
        end
        if (mid_stb) begin
            if (first_mid < 0) first_mid = cyc - sop_cyc;
            if (last_mid >= 0) gap = cyc - last_mid;
            last_mid = cyc;
            nmid++;
        end
        if (edge_stb && first_edge < 0) first_edge = cyc - sop_cyc;
        sop = req_sop;
        if (req_sop) begin
            req_sop = 1'b0;
            m_act  = 1'b1;
            m_rate = rate_fast;
            m_per  = rate_fast ? NOM_F : NOM_S;
            m_pos  = {m_cnt, 16'h0} - (m_per >> 1) + 32'h8000 + m_per;
            m_prev = rate_fast ? 2'b01 : 2'b10;
            m_edge = 2'b00;
            cur    = m_prev;
            sop_cyc = cyc; first_mid = -1; first_edge = -1; last_mid = -1; nmid = 0; gap = 0;
        end else begin
            if (ee) begin
                edge_line = (pol == 1) ? ~cur : (pol == 3) ? 2'b00 : cur;
                m_edge = edge_line;
            end
            if (em) begin
                if (pol != 0) cur = ~cur;
                mid_line = cur;
                tr    = diff_sym(cur) && (cur != m_prev) && diff_sym(m_edge);
                early = (m_edge == cur);
                pn = m_per;
                ph = 64'd0;
                if (tr) begin
                    nom = m_rate ? NOM_F : NOM_S;
                    tol = (nom * 32'd3) / 32'd100;
                    lo = nom - tol; hi = nom + tol;
                    st = (64'(m_per) * 64'd33) >> 15;
                    pn = early ? m_per - st[31:0] : m_per + st[31:0];
                    if (pn < lo) pn = lo;
                    if (pn > hi) pn = hi;
                    ph = (64'(pn) * 64'd41) >> 12;
                end
                m_pos = m_pos + m_per;
                if (tr) m_pos = early ? m_pos - ph[31:0] : m_pos + ph[31:0];
                m_per  = pn;
                m_prev = cur;
            end
        end
        @(negedge clk);
        cyc++;
        m_cnt++;
    endtask

    task automatic start_pkt(input logic fast, input int p);
        rate_fast = fast;
        pol = p;
        req_sop = 1'b1;
        tick();
    endtask

    task automatic run_mids(input int n);
        int guard = 0;
        while (nmid < n && guard < 8000) begin
            tick();
            guard++;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; sop = 1'b0; req_sop = 1'b0; m_act = 1'b0; pol = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = '0;
        chk(mid_stb == 1'b0 && edge_stb == 1'b0, "R1 strobes low after reset",
            int'({mid_stb, edge_stb}), 0);
        nstb = 0;
        repeat (80) tick();
        chk(nstb == 0, "R1 no strobes before first start pulse", nstb, 0);
    endtask

    task automatic t_slow_nominal();
        start_pkt(1'b0, 0);
        run_mids(6);
        chk(first_mid == 16, "R3 first slow mid strobe offset", first_mid, 16);
        chk(first_edge == 32, "R4 first slow edge strobe offset", first_edge, 32);
        chk(gap == 32, "R2 slow mid spacing", gap, 32);
    endtask

    task automatic t_fast_nominal();
        start_pkt(1'b1, 0);
        run_mids(6);
        chk(first_mid == 2, "R2 first fast mid strobe offset", first_mid, 2);
        chk(first_edge == 4, "R4 first fast edge strobe offset", first_edge, 4);
        chk(gap == 4, "R2 fast mid spacing", gap, 4);
    endtask

    task automatic t_no_correction();
        start_pkt(1'b0, 3);
        run_mids(20);
        chk(last_mid - sop_cyc == 16 + 32 * 19, "R5 single-ended edge leaves timing",
            last_mid - sop_cyc, 16 + 32 * 19);
        chk(gap == 32, "R5 spacing stays nominal", gap, 32);
    endtask

    task automatic t_early();
        start_pkt(1'b0, 1);
        run_mids(12);
        chk(last_mid - sop_cyc < 16 + 32 * 11, "R6 early edges pull strobes in",
            last_mid - sop_cyc, 16 + 32 * 11);
    endtask

    task automatic t_late();
        start_pkt(1'b0, 2);
        run_mids(12);
        chk(last_mid - sop_cyc > 16 + 32 * 11, "R7 late edges push strobes out",
            last_mid - sop_cyc, 16 + 32 * 11);
    endtask

    task automatic t_clamp_low();
        start_pkt(1'b0, 1);
        run_mids(150);
        chk(gap >= 30 && gap <= 31, "R8 lower period limit spacing", gap, 30);
    endtask

    task automatic t_clamp_high();
        start_pkt(1'b0, 2);
        run_mids(150);
        chk(gap >= 33 && gap <= 34, "R8 upper period limit spacing", gap, 33);
    endtask

    task automatic t_resync();
        start_pkt(1'b0, 2);
        run_mids(3);
        repeat (5) tick();
        start_pkt(1'b1, 0);
        run_mids(4);
        chk(first_mid == 2, "R9 restart mid offset", first_mid, 2);
        chk(gap == 4, "R9 restart spacing at new rate", gap, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_slow_nominal();
        t_fast_nominal();
        t_no_correction();
        t_early();
        t_late();
        t_clamp_low();
        t_clamp_high();
        t_resync();
        repeat (4) tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule